// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the countdown timer of a per-core local interrupt controller. Software programs it through a small 32-bit register port addressed by word offset. The programmable state is a timer entry (vector, mask bit and mode field), an initial-count register, a divide-configuration register and a spurious-vector register that carries the software-enable bit. The current count is read-only and reads back live. A single-cycle `tick_en` pulse stands in for the base clock. The divide setting slows that tick by a power of two, and the current count drops by one on each divided tick.

When the count reaches zero the timer expires. In one-shot mode it then stops. In periodic mode it reloads from the initial count and keeps running. If the entry is unmasked, expiry raises an edge-type interrupt request that carries the entry's vector. The request leaves on a valid/ready pair. `irq_valid` and `irq_vector` hold steady until `irq_ready` is seen high on a clock edge. An expiry that occurs while a request is still waiting is merged into that request, and the stored vector is kept. The receiver can therefore stall for any length of time without losing the fact that an interrupt is due.

A deadline mode value can be stored when the `DEADLINE_OK` parameter allows it. In that mode the countdown freezes, initial-count writes are dropped and the timer never fires. When the mode is not supported, a write that requests it is handled by `ext_mode`: with `ext_mode` low the mode field is stored as one-shot, and with `ext_mode` high the write is refused.

Top module: `lt_timer`

## Requirements
- R1: After reset, the current count, initial count and divide registers read 0, the timer entry (offset 0) reads 0x00010000 (mask bit 16 set, vector 0, mode 0), and `irq_valid` is 0.
- R2: A write to the initial-count register (offset 1) loads the same value into the current count (offset 2), and the new value reads back in the next cycle.
- R3: The divide code is {bit3, bit1, bit0} of offset 3. Codes 000 to 110 divide by 2 to 128, and code 111 divides by 1. The current count drops by one per divided tick, so an initial count N expires on the (N × divisor)-th `tick_en` pulse after the write.
- R4: In one-shot mode (entry bits 18:17 = 00), expiry leaves the current count at 0, and further ticks neither change it nor raise a request.
- R5: In periodic mode (bits 18:17 = 01), expiry reloads the current count from the initial count and raises a request on every period.
- R6: Writing 0 to the initial count stops the timer: the current count reads 0 and no request follows.
- R7: At expiry, a request with the entry's vector (bits 7:0) is raised only when the mask bit (bit 16) is 0. A masked expiry raises nothing.
- R8: `irq_valid` and `irq_vector` stay stable until a cycle with `irq_ready` high. An expiry during a waiting request keeps the first vector and is merged into that request.
- R9: With `DEADLINE_OK`=1 and mode 10 stored, initial-count writes are ignored, the current count does not change, and no request is raised.
- R10: With `DEADLINE_OK`=0, an entry write that requests mode 10 is stored with mode 00 when `ext_mode` is 0. When `ext_mode` is 1, the write raises `wr_reject` in the write cycle and leaves the entry unchanged.
- R11: Writing offset 4 with bit 8 (software enable) at 0 sets the entry's mask bit. An entry written while the enable bit is 0 is stored masked.
- R12: A write to the current-count offset (2) has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base timer tick, one cycle per tick |
| ext_mode | input | 1 | Extended register-access mode; refuses unsupported entry writes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word offset |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| wr_reject | output | 1 | High while a write is being refused |
| irq_valid | output | 1 | Interrupt request pending |
| irq_ready | input | 1 | Receiver accepts the request |
| irq_vector | output | 8 | Vector of the pending request |

## Verification
The bench builds two copies side by side from the same stimulus: one with `DEADLINE_OK`=1 and one with the default `DEADLINE_OK`=0, both with a 32-bit count. The first copy reaches the frozen deadline behaviour. The second copy reaches the legacy clearing of the deadline request and the extended-mode refusal of it. Divide settings of 1, 2, 32 and 128 are checked exactly one tick before and at the expiry tick, which exercises both ends of the decode and the prescaler.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int REG_AW   = 3;
  localparam int LVT_W    = 19;
  localparam int VEC_W    = 8;
  localparam int MASK_BIT = 16;
  localparam int PRE_W    = 7;
  localparam int SHIFT_W  = 3;

  localparam logic [REG_AW-1:0] OFF_LVT  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_INIT = 3'd1;
  localparam logic [REG_AW-1:0] OFF_CUR  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_DIV  = 3'd3;
  localparam logic [REG_AW-1:0] OFF_SVR  = 3'd4;

  localparam logic [LVT_W-1:0] LVT_KEEP = 19'h700FF;

  localparam logic [1:0] MODE_ONESHOT  = 2'b00;
  localparam logic [1:0] MODE_PERIODIC = 2'b01;
  localparam logic [1:0] MODE_DEADLINE = 2'b10;

  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] dcr);
    logic [2:0] code;
    code = {dcr[3], dcr[1], dcr[0]};
    return (code == 3'b111) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lt_pkg::*;
#(
  parameter bit DEADLINE_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [LVT_W-1:0]  wr_lo,
  output logic [LVT_W-1:0]  lvt_q,
  output logic [3:0]        dcr_q,
  output logic [8:0]        svr_q,
  output logic              reject
);
  logic             wr_lvt, wr_svr, dl_req;
  logic [LVT_W-1:0] lvt_new;

  assign wr_lvt = wr_en && (wr_addr == OFF_LVT);
  assign wr_svr = wr_en && (wr_addr == OFF_SVR);
  assign dl_req = (wr_lo[18:17] == MODE_DEADLINE);
  assign reject = wr_lvt && dl_req && !DEADLINE_OK && ext_mode;

  always_comb begin
    lvt_new = wr_lo & LVT_KEEP;
    if (dl_req && !DEADLINE_OK) lvt_new[18:17] = MODE_ONESHOT;
    if (!svr_q[8])              lvt_new[MASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvt_q <= '0;
      lvt_q[MASK_BIT] <= 1'b1;
      dcr_q <= '0;
      svr_q <= '0;
    end else begin
      if (wr_lvt && !reject) lvt_q <= lvt_new;
      if (wr_en && wr_addr == OFF_DIV) dcr_q <= wr_lo[3:0] & 4'hB;
      if (wr_svr) begin
        svr_q <= wr_lo[8:0];
        if (!wr_lo[8]) lvt_q[MASK_BIT] <= 1'b1;
      end
    end
  end

  // R10
  lvt_reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> $stable(lvt_q));
  // R11
  sw_disable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_svr && !wr_lo[8]) |=> lvt_q[MASK_BIT]);
endmodule

// File: rtl/lt_prescale.sv
module lt_prescale
  import lt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               div_tick
);
  logic [PRE_W-1:0] cnt, msk;

  assign msk      = ~({PRE_W{1'b1}} << shift);
  assign div_tick = tick_en && ((cnt & msk) == msk);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (tick_en)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lt_count.sv
module lt_count
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             icr_wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic [1:0]       mode,
  input  logic             div_tick,
  output logic [CNT_W-1:0] icr_q,
  output logic [CNT_W-1:0] ccr_q,
  output logic             restart,
  output logic             expire
);
  logic running, is_dl, is_per;

  assign is_dl   = (mode == MODE_DEADLINE);
  assign is_per  = (mode == MODE_PERIODIC);
  assign restart = icr_wr && !is_dl;
  assign expire  = div_tick && running && !is_dl && !restart
                   && (ccr_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icr_q   <= '0;
      ccr_q   <= '0;
      running <= 1'b0;
    end else if (restart) begin
      icr_q   <= wr_val;
      ccr_q   <= wr_val;
      running <= (wr_val != '0);
    end else if (div_tick && running && !is_dl) begin
      if (ccr_q == CNT_W'(1)) begin
        ccr_q   <= is_per ? icr_q : '0;
        running <= is_per;
      end else begin
        ccr_q <= ccr_q - 1'b1;
      end
    end
  end

  // R2
  init_loads_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ccr_q == $past(wr_val)));
  // R4
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !is_per) |=> (ccr_q == '0) && !running);
  // R5
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && is_per) |=> (ccr_q == icr_q) && running);
  // R9
  deadline_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_wr && is_dl) |=> $stable(icr_q) && $stable(ccr_q));
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter bit DEADLINE_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ext_mode,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              wr_reject,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [LVT_W-1:0] lvt_q;
  logic [3:0]       dcr_q;
  logic [8:0]       svr_q;
  logic [CNT_W-1:0] icr_q, ccr_q;
  logic             restart, expire, div_tick;

  lt_regs #(.DEADLINE_OK(DEADLINE_OK)) regs_i (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_lo(wr_data[LVT_W-1:0]), .lvt_q(lvt_q),
    .dcr_q(dcr_q), .svr_q(svr_q), .reject(wr_reject)
  );

  lt_prescale pre_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .shift(div_shift(dcr_q)), .div_tick(div_tick)
  );

  lt_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .icr_wr(wr_en && wr_addr == OFF_INIT),
    .wr_val(wr_data[CNT_W-1:0]), .mode(lvt_q[18:17]), .div_tick(div_tick),
    .icr_q(icr_q), .ccr_q(ccr_q), .restart(restart), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      if (irq_valid && irq_ready) irq_valid <= 1'b0;
      if (expire && !lvt_q[MASK_BIT] && (!irq_valid || irq_ready)) begin
        irq_valid  <= 1'b1;
        irq_vector <= lvt_q[VEC_W-1:0];
      end
    end
  end

  always_comb begin
    case (rd_addr)
      OFF_LVT:  rd_data = 32'(lvt_q);
      OFF_INIT: rd_data = 32'(icr_q);
      OFF_CUR:  rd_data = 32'(ccr_q);
      OFF_DIV:  rd_data = 32'(dcr_q);
      OFF_SVR:  rd_data = 32'(svr_q);
      default:  rd_data = '0;
    endcase
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> irq_valid && $stable(irq_vector));
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && lvt_q[MASK_BIT] && !wr_en) |=> !irq_valid);
endmodule

// File: tb/lt_timer_tb_top.sv
`timescale 1ns/1ps
module lt_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, ext_mode = 1'b0;
  logic        wr_en = 1'b0, irq_ready = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a, rd_b;
  logic        rej_a, rej_b, vld_a, vld_b;
  logic [7:0]  vec_a, vec_b;
  logic        rj_i, rj_nd;
  int          total = 0, fails = 0;

  always #4 clk = ~clk;

  lt_timer #(.CNT_W(32), .DEADLINE_OK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_a), .wr_reject(rej_a), .irq_valid(vld_a),
    .irq_ready(irq_ready), .irq_vector(vec_a));

  lt_timer #(.CNT_W(32)) dut_nd_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_b), .wr_reject(rej_b), .irq_valid(vld_b),
    .irq_ready(irq_ready), .irq_vector(vec_b));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1; rj_i = rej_a; rj_nd = rej_b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] va, output logic [31:0] vb);
    rd_addr = a; #1; va = rd_a; vb = rd_b;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic accept();
    irq_ready = 1'b1; @(negedge clk); irq_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    rd(3'd0, a, b); chk("R1 entry", a, 32'h00010000);
    rd(3'd2, a, b); chk("R1 cur", a, 0);
    rd(3'd1, a, b); chk("R1 init", a, 0);
    rd(3'd3, a, b); chk("R1 div", a, 0);
    chk("R1 irq", 32'(vld_a), 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] a, b;
    wr(3'd4, 32'h100); wr(3'd0, 32'h40); wr(3'd3, 32'hB);
    wr(3'd1, 5);
    rd(3'd2, a, b); chk("R2 load", a, 5);
    ticks(2); rd(3'd2, a, b); chk("R3 live count", a, 3);
    ticks(2); rd(3'd2, a, b); chk("R3 before expiry", a, 1);
    chk("R3 no early irq", 32'(vld_a), 0);
    ticks(1);
    chk("R7 irq raised", 32'(vld_a), 1);
    chk("R7 vector", 32'(vec_a), 32'h40);
    rd(3'd2, a, b); chk("R4 cur zero", a, 0);
    accept(); chk("R8 accepted", 32'(vld_a), 0);
    ticks(10); rd(3'd2, a, b); chk("R4 stays stopped", a, 0);
    chk("R4 no second irq", 32'(vld_a), 0);
  endtask

  task automatic t_divide(input logic [31:0] dcr, input int n, input int div);
    wr(3'd3, dcr); wr(3'd1, n);
    ticks(n * div - 1);
    chk($sformatf("R3 div%0d not yet", div), 32'(vld_a), 0);
    ticks(1);
    chk($sformatf("R3 div%0d expiry", div), 32'(vld_a), 1);
    accept();
  endtask

  task automatic t_periodic();
    logic [31:0] a, b;
    wr(3'd3, 32'hB); wr(3'd0, 32'h20041); wr(3'd1, 3);
    ticks(3);
    chk("R5 irq", 32'(vld_a), 1);
    chk("R5 vector", 32'(vec_a), 32'h41);
    rd(3'd2, a, b); chk("R5 reload", a, 3);
    wr(3'd0, 32'h20042);
    ticks(3);
    chk("R8 still pending", 32'(vld_a), 1);
    chk("R8 first vector kept", 32'(vec_a), 32'h41);
    accept(); chk("R8 drop on ready", 32'(vld_a), 0);
    ticks(3);
    chk("R5 next period", 32'(vld_a), 1);
    chk("R5 new vector", 32'(vec_a), 32'h42);
    accept();
    wr(3'd1, 0);
    rd(3'd2, a, b); chk("R6 cur zero", a, 0);
    ticks(10); chk("R6 no irq", 32'(vld_a), 0);
  endtask

  task automatic t_masked();
    logic [31:0] a, b;
    wr(3'd0, 32'h10050); wr(3'd1, 2); ticks(2);
    chk("R7 masked quiet", 32'(vld_a), 0);
    rd(3'd2, a, b); chk("R7 masked expired", a, 0);
  endtask

  task automatic t_deadline();
    logic [31:0] a, b;
    wr(3'd1, 7); ticks(2);
    wr(3'd0, 32'h40060);
    rd(3'd0, a, b);
    chk("R9 deadline stored", a, 32'h40060);
    chk("R10 legacy clears mode", b, 32'h60);
    wr(3'd1, 4);
    rd(3'd1, a, b); chk("R9 init ignored", a, 7);
    rd(3'd2, a, b); chk("R9 cur kept", a, 5);
    chk("R10 legacy init accepted", b, 4);
    ticks(20);
    rd(3'd2, a, b); chk("R9 frozen", a, 5);
    chk("R9 never fires", 32'(vld_a), 0);
    chk("R10 one-shot fires", 32'(vld_b), 1);
    chk("R10 one-shot vector", 32'(vec_b), 32'h60);
    accept();
    ext_mode = 1'b1;
    wr(3'd0, 32'h40070);
    chk("R10 reject flagged", 32'(rj_nd), 1);
    chk("R10 supported no reject", 32'(rj_i), 0);
    rd(3'd0, a, b); chk("R10 entry unchanged", b, 32'h60);
    ext_mode = 1'b0;
  endtask

  task automatic t_enable();
    logic [31:0] a, b;
    wr(3'd0, 32'h45);
    wr(3'd4, 32'h0);
    rd(3'd0, a, b); chk("R11 mask forced", a, 32'h10045);
    wr(3'd0, 32'h46);
    rd(3'd0, a, b); chk("R11 stored masked", a, 32'h10046);
  endtask

  task automatic t_curwrite();
    logic [31:0] a, b;
    wr(3'd4, 32'h100); wr(3'd0, 32'h10000); wr(3'd1, 9);
    wr(3'd2, 3);
    rd(3'd2, a, b); chk("R12 cur write ignored", a, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_divide(32'h0, 3, 2);
    t_divide(32'h8, 2, 32);
    t_divide(32'hA, 1, 128);
    t_periodic();
    t_masked();
    t_deadline();
    t_enable();
    t_curwrite();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule